// File: doc/BRIEF.md
# Bidirectional Encoder Position Counter

This block keeps a position count for a rotary or linear encoder. A phase decoder upstream turns the two encoder phases into single-cycle count-up and count-down strobes. Each strobe moves a 16-bit counter by one. The block holds two compare values. When the counter lands on either value, a one-cycle interrupt pulse is raised. Each compare channel can also be armed so that, while the counter sits on its value, the next upward step returns the counter to zero instead of incrementing it.

An underflow happens when the counter steps down from zero. It raises an interrupt pulse and sets a sticky flag. If reload is enabled, the counter takes the value of compare channel 0 instead of wrapping to all ones. Combining reload with clearing on channel 0 makes a modulo counter that runs between zero and the channel 0 value in both directions, which is the usual setup for one mechanical revolution.

Stepping up past all ones sets a sticky overflow flag. A direction flag records which way the last accepted step went. Software configures the block through a small synchronous write port and clears the sticky flags with write-one strobes.

Top module: `qenc_pos_counter`

## Requirements
- R1: After synchronous reset the position is 0x0000, both sticky flags and all three interrupt outputs are 0, the direction flag is 1, and both compare values and all control bits are 0.
- R2: A write sets a register chosen by the address: 0 is compare channel 0, 1 is compare channel 1, 2 is control and 3 is a direct position preset. In the control word, bits [1:0] park channels 1:0 (a 0 bit means compare mode), bits [3:2] are the clear-enables for channels 1:0, and bit 4 enables reload. A preset wins over a count strobe in the same cycle, raises no interrupt and leaves the direction flag unchanged.
- R3: While run is 1, a lone up strobe adds one and a lone down strobe subtracts one. The result is visible on the clock edge that samples the strobe. The direction flag becomes 1 after an up step and 0 after a down step.
- R4: While run is 0, or when both strobes are 1 in the same cycle, the position and direction flag hold and no interrupt is raised.
- R5: For a channel whose park bit is 0, a step whose result equals that channel's compare value pulses the channel's interrupt for exactly the cycle in which the new position first shows. A parked channel never pulses.
- R6: If a channel is not parked, its clear-enable bit is 1 and the position equals its compare value, the next up step makes the position 0x0000. A down step from that value decrements normally. With the clear-enable bit at 0, a match never clears the counter.
- R7: A down step from 0x0000 pulses the underflow interrupt and sets the underflow flag. The new position is compare value 0 when reload is enabled and 0xFFFF otherwise.
- R8: An up step from 0xFFFF that is not a clearing step gives 0x0000 and sets the overflow flag. It raises no interrupt.
- R9: The flag-clear input clears the underflow flag with bit 0 and the overflow flag with bit 1. Otherwise both flags hold their value. A flag set in the same cycle as its clear remains set.
- R10: With reload enabled, channel 0 unparked and its clear-enable bit set, a position that starts at or below compare value 0 stays within 0x0000 to that value for any mix of up and down steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Counting enable; strobes are ignored while low |
| cnt_up | input | 1 | One-cycle up step strobe |
| cnt_dn | input | 1 | One-cycle down step strobe |
| flag_clr | input | 2 | Write-one clear: bit 0 underflow flag, bit 1 overflow flag |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Register write data |
| position | output | 16 | Current counter value |
| dir_up | output | 1 | 1 if the last accepted step was upward |
| uf_flag | output | 1 | Sticky underflow flag |
| ov_flag | output | 1 | Sticky overflow flag |
| irq_match0 | output | 1 | Match pulse for compare channel 0 |
| irq_match1 | output | 1 | Match pulse for compare channel 1 |
| irq_underflow | output | 1 | Underflow pulse |

## Verification
Every internal state of this counter drives an output register directly, so a wrong next-value choice appears on `position` on the clock edge that takes the faulty step. An error that only arms a clear or a reload appears one step later, when the counter fails to return to zero or to the reload value. The bench sweeps all combinations of reload, clear-enable and park settings over a small range, and compares every output after every step against an arithmetic model. A wrong match comparison, a wrong priority or a misrouted flag therefore shows within a few dozen steps.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  localparam int N_CMP  = 2;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADR_CMP0 = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_CMP1 = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_POS  = 2'd3;

  // control word layout, msb first: reload, clear-enables, park bits
  typedef struct packed {
    logic                 reload_en;
    logic [N_CMP-1:0]     clr_en;
    logic [N_CMP-1:0]     park;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/qenc_regs.sv
module qenc_regs
  import qenc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [CNT_W-1:0]      wr_data,
  output logic [CNT_W-1:0]      cmp_val [N_CMP],
  output ctrl_t                 ctrl,
  output logic                  pos_wr,
  output logic [CNT_W-1:0]      pos_wr_val
);

  // compare value storage, one register per channel at address = index
  for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
    logic [CNT_W-1:0] val_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        val_q <= '0;
      end else if (wr_en && (wr_addr == ADDR_W'(g))) begin
        val_q <= wr_data;
      end
    end
    assign cmp_val[g] = val_q;
  end

  ctrl_t ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_en && (wr_addr == ADR_CTRL)) begin
      ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
    end
  end

  assign ctrl       = ctrl_q;
  assign pos_wr     = wr_en && (wr_addr == ADR_POS);
  assign pos_wr_val = wr_data;

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADR_CTRL) |=> (ctrl == $past(wr_data[CTRL_W-1:0]))); // R2

endmodule

// File: rtl/qenc_match.sv
module qenc_match #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic             step,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             park,
  input  logic             clr_en,
  output logic             clr_arm,
  output logic             irq
);

  logic hit_now;
  logic irq_q;

  // the counter already sits on the compare value: the next up step clears
  assign hit_now = (cnt_q == cmp_val);
  assign clr_arm = ~park & clr_en & hit_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= step & ~park & (cnt_nxt == cmp_val);
    end
  end

  assign irq = irq_q;

  AST_MATCH_VALUE: assert property (@(posedge clk) disable iff (rst)
    irq |-> (cnt_q == $past(cmp_val))); // R5
  AST_MATCH_PARKED: assert property (@(posedge clk) disable iff (rst)
    irq |-> !$past(park)); // R5

endmodule

// File: rtl/qenc_core.sv
module qenc_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             cnt_up,
  input  logic             cnt_dn,
  input  logic [1:0]       flag_clr,
  input  logic             reload_en,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             clr_any,
  input  logic             pos_wr,
  input  logic [CNT_W-1:0] pos_wr_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             step,
  output logic             dir_up,
  output logic             uf_flag,
  output logic             ov_flag,
  output logic             irq_uf
);

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  logic step_up, step_dn;
  logic uf_hit, ov_hit;

  assign step    = run & (cnt_up ^ cnt_dn) & ~pos_wr;
  assign step_up = step & cnt_up;
  assign step_dn = step & cnt_dn;
  assign uf_hit  = step_dn & (cnt_q == CNT_ZERO);
  assign ov_hit  = step_up & ~clr_any & (cnt_q == CNT_MAX);

  always_comb begin
    cnt_nxt = cnt_q;
    if (pos_wr) begin
      cnt_nxt = pos_wr_val;
    end else if (step_up) begin
      cnt_nxt = clr_any ? CNT_ZERO : cnt_q + 1'b1;
    end else if (step_dn) begin
      if (uf_hit) begin
        cnt_nxt = reload_en ? reload_val : CNT_MAX;
      end else begin
        cnt_nxt = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      dir_up  <= 1'b1;
      uf_flag <= 1'b0;
      ov_flag <= 1'b0;
      irq_uf  <= 1'b0;
    end else begin
      cnt_q   <= cnt_nxt;
      if (step) begin
        dir_up <= step_up;
      end
      uf_flag <= (uf_flag & ~flag_clr[0]) | uf_hit;
      ov_flag <= (ov_flag & ~flag_clr[1]) | ov_hit;
      irq_uf  <= uf_hit;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((!run || (cnt_up == cnt_dn)) && !pos_wr) |=> ($stable(cnt_q) && $stable(dir_up))); // R4
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (run && cnt_up && !cnt_dn && !pos_wr && clr_any) |=> (cnt_q == CNT_ZERO)); // R6
  AST_UF_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (run && cnt_dn && !cnt_up && !pos_wr && cnt_q == CNT_ZERO && reload_en)
      |=> (cnt_q == $past(reload_val))); // R7
  AST_UF_STICKY: assert property (@(posedge clk) disable iff (rst)
    irq_uf |-> uf_flag); // R7
  AST_OV_WRAP: assert property (@(posedge clk) disable iff (rst)
    (run && cnt_up && !cnt_dn && !pos_wr && !clr_any && cnt_q == CNT_MAX)
      |=> (ov_flag && cnt_q == CNT_ZERO)); // R8
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (uf_flag && !flag_clr[0]) |=> uf_flag); // R9

endmodule

// File: rtl/qenc_pos_counter.sv
module qenc_pos_counter
  import qenc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             cnt_up,
  input  logic             cnt_dn,
  input  logic [1:0]       flag_clr,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] position,
  output logic             dir_up,
  output logic             uf_flag,
  output logic             ov_flag,
  output logic             irq_match0,
  output logic             irq_match1,
  output logic             irq_underflow
);

  logic [CNT_W-1:0] cmp_val [N_CMP];
  ctrl_t            ctrl;
  logic             pos_wr;
  logic [CNT_W-1:0] pos_wr_val;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             step;
  logic [N_CMP-1:0] clr_arm;
  logic [N_CMP-1:0] irq_cmp;

  qenc_regs #(.CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .cmp_val    (cmp_val),
    .ctrl       (ctrl),
    .pos_wr     (pos_wr),
    .pos_wr_val (pos_wr_val)
  );

  for (genvar g = 0; g < N_CMP; g++) begin : g_ch
    qenc_match #(.CNT_W(CNT_W)) u_match (
      .clk     (clk),
      .rst     (rst),
      .cnt_q   (cnt_q),
      .cnt_nxt (cnt_nxt),
      .step    (step),
      .cmp_val (cmp_val[g]),
      .park    (ctrl.park[g]),
      .clr_en  (ctrl.clr_en[g]),
      .clr_arm (clr_arm[g]),
      .irq     (irq_cmp[g])
    );
  end

  qenc_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .cnt_up     (cnt_up),
    .cnt_dn     (cnt_dn),
    .flag_clr   (flag_clr),
    .reload_en  (ctrl.reload_en),
    .reload_val (cmp_val[0]),
    .clr_any    (|clr_arm),
    .pos_wr     (pos_wr),
    .pos_wr_val (pos_wr_val),
    .cnt_q      (cnt_q),
    .cnt_nxt    (cnt_nxt),
    .step       (step),
    .dir_up     (dir_up),
    .uf_flag    (uf_flag),
    .ov_flag    (ov_flag),
    .irq_uf     (irq_underflow)
  );

  assign position   = cnt_q;
  assign irq_match0 = irq_cmp[0];
  assign irq_match1 = irq_cmp[1];

  AST_PRESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    pos_wr |=> (!irq_match0 && !irq_match1 && !irq_underflow && position == $past(wr_data))); // R2
  AST_MOD_RANGE: assert property (@(posedge clk) disable iff (rst)
    (ctrl.reload_en && ctrl.clr_en[0] && !ctrl.park[0] && !pos_wr && !wr_en
      && position <= cmp_val[0]) |=> (position <= cmp_val[0])); // R10

endmodule

// File: tb/qenc_pos_counter_test.sv
module qenc_pos_counter_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic        cnt_up = 1'b0;
  logic        cnt_dn = 1'b0;
  logic [1:0]  flag_clr = 2'b00;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'b00;
  logic [15:0] wr_data = 16'h0000;
  logic [15:0] position;
  logic        dir_up, uf_flag, ov_flag;
  logic        irq_match0, irq_match1, irq_underflow;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  logic [15:0] m_cnt = 16'h0000;
  logic [15:0] m_c0 = 16'h0000, m_c1 = 16'h0000;
  logic [1:0]  m_park = 2'b00, m_clr = 2'b00;
  logic        m_load = 1'b0;
  logic        m_dir = 1'b1, m_uf = 1'b0, m_ov = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  qenc_pos_counter uut (
    .clk(clk), .rst(rst), .run(run), .cnt_up(cnt_up), .cnt_dn(cnt_dn),
    .flag_clr(flag_clr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .position(position), .dir_up(dir_up), .uf_flag(uf_flag), .ov_flag(ov_flag),
    .irq_match0(irq_match0), .irq_match1(irq_match1), .irq_underflow(irq_underflow)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // register write with counting stopped; the model mirrors the effect
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    run = 1'b0; cnt_up = 1'b0; cnt_dn = 1'b0; flag_clr = 2'b00;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    case (a)
      2'd0: m_c0 = d;
      2'd1: m_c1 = d;
      2'd2: begin m_park = d[1:0]; m_clr = d[3:2]; m_load = d[4]; end
      default: m_cnt = d;
    endcase
    @(posedge clk); #1;
    wr_en = 1'b0;
    chk("R2", "position after write", {16'h0, position}, {16'h0, m_cnt});
  endtask

  task automatic step(input logic u, input logic d, input logic r, input logic [1:0] c);
    logic [15:0] n;
    logic i0, i1, iu, moved, cleared, setov;
    string t;
    @(negedge clk);
    run = r; cnt_up = u; cnt_dn = d; flag_clr = c;
    moved = r && (u != d);
    cleared = 1'b0; setov = 1'b0; iu = 1'b0; n = m_cnt;
    if (moved && u) begin
      cleared = (!m_park[0] && m_clr[0] && m_cnt == m_c0) ||
                (!m_park[1] && m_clr[1] && m_cnt == m_c1);
      if (cleared) n = 16'h0000;
      else begin
        setov = (m_cnt == 16'hFFFF);
        n = m_cnt + 16'd1;
      end
      m_dir = 1'b1;
    end else if (moved) begin
      iu = (m_cnt == 16'h0000);
      n = iu ? (m_load ? m_c0 : 16'hFFFF) : m_cnt - 16'd1;
      m_dir = 1'b0;
    end
    i0 = moved && !m_park[0] && n == m_c0;
    i1 = moved && !m_park[1] && n == m_c1;
    m_uf = (m_uf & ~c[0]) | iu;
    m_ov = (m_ov & ~c[1]) | setov;
    m_cnt = n;
    if (!moved) t = "R4";
    else if (cleared) t = "R6";
    else if (iu) t = "R7";
    else if (setov) t = "R8";
    else t = "R3";
    @(posedge clk); #1;
    chk(t, "position", {16'h0, position}, {16'h0, m_cnt});
    chk(moved ? "R3" : "R4", "dir_up", {31'h0, dir_up}, {31'h0, m_dir});
    chk("R5", "irq_match0", {31'h0, irq_match0}, {31'h0, i0});
    chk("R5", "irq_match1", {31'h0, irq_match1}, {31'h0, i1});
    chk("R7", "irq_underflow", {31'h0, irq_underflow}, {31'h0, iu});
    chk(c[0] ? "R9" : "R7", "uf_flag", {31'h0, uf_flag}, {31'h0, m_uf});
    chk(c[1] ? "R9" : "R8", "ov_flag", {31'h0, ov_flag}, {31'h0, m_ov});
    if (m_load && m_clr[0] && !m_park[0])
      chk("R10", "modulo range", {31'h0, position <= m_c0}, 32'h1);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1", "position", {16'h0, position}, 32'h0);
    chk("R1", "dir_up", {31'h0, dir_up}, 32'h1);
    chk("R1", "flags", {30'h0, uf_flag, ov_flag}, 32'h0);
    chk("R1", "irqs", {29'h0, irq_match0, irq_match1, irq_underflow}, 32'h0);
    // R1 zero compare values: an up then down step back to 0 matches both channels
    step(1'b1, 1'b0, 1'b1, 2'b00);
    step(1'b0, 1'b1, 1'b1, 2'b00);

    // R7 / R8 / R9 with default control: wraps, sticky flags, clears
    step(1'b0, 1'b1, 1'b1, 2'b00);             // 0 -> FFFF, underflow
    step(1'b1, 1'b0, 1'b1, 2'b00);             // FFFF -> 0, overflow
    step(1'b0, 1'b0, 1'b1, 2'b10);             // R9 clear overflow only
    step(1'b0, 1'b0, 1'b1, 2'b01);             // R9 clear underflow
    step(1'b0, 1'b1, 1'b1, 2'b01);             // R9 set wins over clear
    chk("R9", "uf set beats clear", {31'h0, uf_flag}, 32'h1);

    // R2 preset in same cycle as an up strobe: preset wins, no irq
    wr(2'd0, 16'h1234);
    @(negedge clk);
    run = 1'b1; cnt_up = 1'b1; cnt_dn = 1'b0; flag_clr = 2'b00;
    wr_en = 1'b1; wr_addr = 2'd3; wr_data = 16'h1234;
    m_cnt = 16'h1234;
    @(posedge clk); #1;
    wr_en = 1'b0;
    chk("R2", "preset wins", {16'h0, position}, 32'h1234);
    chk("R2", "preset irq quiet", {29'h0, irq_match0, irq_match1, irq_underflow}, 32'h0);
    chk("R2", "preset dir", {31'h0, dir_up}, {31'h0, m_dir});
    step(1'b0, 1'b0, 1'b0, 2'b00);

    // near-exhaustive sweep of control settings over a small range
    for (int cfg = 0; cfg < 32; cfg++) begin
      wr(2'd0, 16'd4);
      wr(2'd1, 16'd2);
      wr(2'd2, cfg[4:0]);
      wr(2'd3, 16'd2);
      step(1'b0, 1'b0, 1'b1, 2'b11);
      for (int k = 0; k < 48; k++) begin
        logic u, d, r;
        logic [1:0] c;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        r = 1'b1; c = 2'b00;
        case (lfsr[1:0])
          2'd0: begin u = 1'b0; d = 1'b1; end
          2'd1: begin u = 1'b1; d = 1'b0; end
          2'd2: begin u = lfsr[2]; d = ~lfsr[2]; end
          default: begin u = 1'b1; d = lfsr[2]; r = lfsr[3]; end
        endcase
        if (lfsr[7:5] == 3'd0) c = lfsr[9:8];
        step(u, d, r, c);
      end
    end

    // R8 overflow with an unarmed clear: FFFF -> 0
    wr(2'd2, 16'h0000);
    wr(2'd3, 16'hFFFF);
    step(1'b1, 1'b0, 1'b1, 2'b00);
    chk("R8", "ov after wrap", {31'h0, ov_flag}, 32'h1);
    // R6 down step from an armed match value decrements
    wr(2'd0, 16'h0010);
    wr(2'd2, 16'h0004);
    wr(2'd3, 16'h0010);
    step(1'b0, 1'b1, 1'b1, 2'b00);
    chk("R6", "down from match", {16'h0, position}, 32'h000F);
    step(1'b1, 1'b0, 1'b1, 2'b00);
    step(1'b1, 1'b0, 1'b1, 2'b00);
    chk("R6", "up after match clears", {16'h0, position}, 32'h0000);

    finish_run();
  end

endmodule